// File: doc/BRIEF.md
# Buffered Serial Transmitter with DMA Request

This block sends bytes on an asynchronous serial line, one start bit, eight data bits and one stop bit per frame, with no parity. A one-byte holding register sits in front of the shift register. Software or a DMA engine writes into the holding register while the previous frame is still being shifted out, so consecutive frames can leave the block with no idle time between them.

An empty flag tells the writer that the holding register can take a new byte. That flag is ANDed with a registered enable bit to form a request line for a DMA engine. When the enable is set, the engine can stream a buffer into the transmitter without any processor involvement.

The bit period is set by a divisor input, counted in clock cycles. A write that arrives while the holding register is still full replaces the held byte and sets a sticky overrun flag.

Top module: `uart_dma_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `txd` is 1, `tx_empty` is 1, `busy` is 0, `dma_req` is 0 and `overrun` is 0; reset also clears an overrun flag that was set earlier.
- R2: A clock edge with `wr_en` high stores `wr_data` in the holding register and makes `tx_empty` 0 in the next cycle.
- R3: When `tx_empty` is 0 and `busy` is 0 at an edge, the held byte moves into the shift register at that edge; in the next cycle `tx_empty` is 1, `busy` is 1 and `txd` is 0.
- R4: A frame on `txd` is one start bit of value 0, then data bits 0 through 7 with bit 0 first, then one stop bit of value 1.
- R5: Each bit lasts `divisor` clock cycles, so `busy` stays high for exactly 10 × `divisor` cycles for a single frame; a `divisor` of 0 acts as 1.
- R6: If a byte is held when the stop bit ends, its start bit begins in the very next cycle with no idle cycle, and `busy` stays high; `busy` falls only when nothing is held.
- R7: Whenever `busy` is 0, `txd` is 1.
- R8: `dma_req` equals `tx_empty` ANDed with the value `dma_en` had at the previous clock edge; with `dma_en` low, `dma_req` stays 0.
- R9: A write arriving while `tx_empty` is 0, at an edge where the held byte is not being moved into the shift register, replaces the held byte (the older byte is never sent) and sets `overrun` to 1. `overrun` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | DATA_W (8) | Byte to transmit |
| dma_en | input | 1 | DMA request enable, registered inside |
| divisor | input | DIV_W (16) | Clock cycles per bit; 0 behaves as 1 |
| txd | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Holding register can accept a byte |
| busy | output | 1 | A frame is being shifted out |
| dma_req | output | 1 | Request for the next byte from a DMA engine |
| overrun | output | 1 | Sticky flag: a held byte was overwritten |

## Verification
The enable property compares `dma_req` with the previous value of `dma_en`, so it assumes `dma_en` is low during reset. The bench holds it low until reset is released. The frame checks assume `divisor` does not change while a frame is in flight, so the bench only changes `divisor` while the line is idle. The DMA stream test writes only in cycles where `dma_req` is high, which rules out overrun there by construction. Overrun is exercised in a separate test with deliberate back-to-back writes.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic LINE_IDLE  = 1'b1;
  localparam logic LINE_START = 1'b0;
  localparam logic LINE_STOP  = 1'b1;

  // Number of line symbols in one frame: start + data + stop.
  function automatic int unsigned frame_symbols(input int unsigned data_w);
    return data_w + 2;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;

  // A divisor of zero is treated as one cycle per bit.
  assign reload = (divisor == '0) ? '0 : divisor - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= reload;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      empty     <= 1'b1;
      overrun   <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_data <= wr_data;
        empty     <= 1'b0;
        // Older byte is lost only if it is not leaving this very edge.
        if (!empty && !take) overrun <= 1'b1;
      end else if (take) begin
        empty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  output logic              txd,
  output logic              busy,
  output logic              ready
);
  localparam int unsigned SYMS = frame_symbols(DATA_W);

  logic [DATA_W:0]  shreg_q;
  logic [CNT_W-1:0] left_q;
  logic             last_tick;

  assign last_tick = busy && tick && (left_q == CNT_W'(1));
  assign ready     = !busy || last_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '1;
      left_q  <= '0;
      busy    <= 1'b0;
      txd     <= LINE_IDLE;
    end else if (load) begin
      shreg_q <= {LINE_STOP, load_data};
      left_q  <= CNT_W'(SYMS);
      busy    <= 1'b1;
      txd     <= LINE_START;
    end else if (busy && tick) begin
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) begin
        busy <= 1'b0;
        txd  <= LINE_IDLE;
      end else begin
        txd     <= shreg_q[0];
        shreg_q <= {LINE_STOP, shreg_q[DATA_W:1]};
      end
    end
  end
endmodule

// File: rtl/uart_dma_tx.sv
module uart_dma_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dma_en,
  input  logic [DIV_W-1:0]  divisor,
  output logic              txd,
  output logic              tx_empty,
  output logic              busy,
  output logic              dma_req,
  output logic              overrun
);
  localparam int unsigned SYMS  = frame_symbols(DATA_W);
  localparam int unsigned CNT_W = $clog2(SYMS + 1);

  logic [DATA_W-1:0] held_byte;
  logic              shift_ready;
  logic              load;
  logic              tick;
  logic              dma_en_q;

  assign load = !tx_empty && shift_ready;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (load),
    .hold_data (held_byte),
    .empty     (tx_empty),
    .overrun   (overrun)
  );

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .run     (busy),
    .divisor (divisor),
    .tick    (tick)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (held_byte),
    .tick      (tick),
    .txd       (txd),
    .busy      (busy),
    .ready     (shift_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) dma_en_q <= 1'b0;
    else     dma_en_q <= dma_en;
  end

  assign dma_req = dma_en_q && tx_empty;
endmodule

// File: rtl/uart_dma_tx_chk.sv
module uart_dma_tx_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              dma_en,
  input logic [DIV_W-1:0]  divisor,
  input logic              txd,
  input logic              tx_empty,
  input logic              busy,
  input logic              dma_req,
  input logic              overrun
);
  assert_write_clears_empty_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_empty);

  assert_load_starts_frame_R3: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !busy && !wr_en) |=> (busy && tx_empty && !txd));

  assert_busy_falls_only_empty_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tx_empty));

  assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  assert_dma_req_gate_R8: assert property (@(posedge clk) disable iff (rst)
    dma_req == (tx_empty && $past(dma_en)));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(wr_en && !tx_empty));
endmodule

bind uart_dma_tx uart_dma_tx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .dma_en   (dma_en),
  .divisor  (divisor),
  .txd      (txd),
  .tx_empty (tx_empty),
  .busy     (busy),
  .dma_req  (dma_req),
  .overrun  (overrun)
);

// File: tb/uart_dma_tx_bench.sv
module uart_dma_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        dma_en = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        txd, tx_empty, busy, dma_req, overrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_dma_tx u_uart_dma_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .dma_en(dma_en),
    .divisor(divisor), .txd(txd), .tx_empty(tx_empty), .busy(busy),
    .dma_req(dma_req), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Return at the first negedge where the start bit is on the line.
  task automatic wait_start(input string req);
    int n = 0;
    while (txd !== 1'b0 && n < 60) begin @(negedge clk); n++; end
    chk(n < 60, req, n, 0);
  endtask

  // Entered at the first start-bit cycle; leaves at the cycle after the stop bit.
  task automatic check_frame(input logic [7:0] b, input int d, input string req);
    for (int k = 0; k < 10; k++) begin
      logic exp_bit;
      logic got;
      int   bad;
      bad = 0;
      exp_bit = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      got = exp_bit;
      for (int c = 0; c < d; c++) begin
        if (txd !== exp_bit) begin bad++; got = txd; end
        @(negedge clk);
      end
      chk(bad == 0, req, int'(got), int'(exp_bit));
    end
  endtask

  task automatic single_frame(input logic [7:0] b, input int div);
    int d;
    d = (div == 0) ? 1 : div;
    divisor = 16'(div);
    send(b);
    wait_start("R3");
    check_frame(b, d, "R4");
    chk(busy == 1'b0, "R5 busy low after 10*divisor", int'(busy), 0);
    chk(txd == 1'b1, "R7 idle high", int'(txd), 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; dma_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1 && tx_empty == 1 && busy == 0 && dma_req == 0 && overrun == 0,
        "R1 in reset", {txd, tx_empty, busy, dma_req, overrun}, 5'b11000);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1 && tx_empty == 1 && busy == 0 && dma_req == 0 && overrun == 0,
        "R1 after reset", {txd, tx_empty, busy, dma_req, overrun}, 5'b11000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] seq [6];
    do_reset();

    // R2 / R3: step-by-step timing of one write on an idle line.
    divisor = 16'd3;
    send(8'hA5);
    chk(tx_empty == 0, "R2 empty cleared", int'(tx_empty), 0);
    chk(busy == 0, "R3 not yet loaded", int'(busy), 0);
    @(negedge clk);
    chk(tx_empty == 1 && busy == 1 && txd == 0, "R3 moved to shifter",
        {tx_empty, busy, txd}, 3'b110);
    check_frame(8'hA5, 3, "R4 A5");
    chk(busy == 0, "R5 duration d=3", int'(busy), 0);

    // R4/R5: all byte values at divisor 1.
    for (int v = 0; v < 256; v++) single_frame(8'(v), 1);

    // R5: several divisors including zero.
    for (int i = 0; i < 5; i++) begin
      int dv;
      dv = (i == 0) ? 0 : (i == 4) ? 7 : i + 1;
      single_frame(8'h5A ^ 8'(i * 29), dv);
      single_frame(8'h80 | 8'(i), dv);
    end

    // R6: back-to-back frames with no gap.
    divisor = 16'd4;
    send(8'h3C);
    wait_start("R6 first start");
    fork
      begin
        check_frame(8'h3C, 4, "R6 frame one");
        chk(busy == 1, "R6 busy stays high", int'(busy), 1);
        check_frame(8'hC3, 4, "R6 frame two no gap");
        chk(busy == 0, "R6 busy falls when empty", int'(busy), 0);
      end
      begin
        send(8'hC3);
        chk(tx_empty == 0, "R2 write during frame", int'(tx_empty), 0);
      end
    join

    // R9: overrun replaces the held byte.
    divisor = 16'd3;
    send(8'h11);
    wait_start("R9 start");
    fork
      begin
        check_frame(8'h11, 3, "R9 first frame");
        check_frame(8'h33, 3, "R9 replaced byte sent");
        chk(busy == 0, "R9 lost byte never sent", int'(busy), 0);
      end
      begin
        send(8'h22);
        chk(overrun == 0, "R9 no overrun yet", int'(overrun), 0);
        send(8'h33);
        chk(overrun == 1, "R9 overrun set", int'(overrun), 1);
      end
    join
    repeat (5) @(negedge clk);
    chk(overrun == 1, "R9 overrun sticky", int'(overrun), 1);
    do_reset();

    // R8: request gating.
    divisor = 16'd2;
    repeat (3) @(negedge clk);
    chk(dma_req == 0 && tx_empty == 1, "R8 disabled no request", {dma_req, tx_empty}, 2'b01);
    dma_en = 1'b1;
    chk(dma_req == 0, "R8 one cycle latency", int'(dma_req), 0);
    @(negedge clk);
    chk(dma_req == 1, "R8 enabled request", int'(dma_req), 1);
    dma_en = 1'b0;
    @(negedge clk);
    chk(dma_req == 0, "R8 request drops with enable", int'(dma_req), 0);
    dma_en = 1'b1;
    @(negedge clk);

    // R8 / R6: DMA-style stream driven only by dma_req.
    for (int i = 0; i < 6; i++) seq[i] = 8'(i * 37 + 11);
    fork
      begin
        int idx = 0;
        while (idx < 6) begin
          if (dma_req) begin wr_en = 1'b1; wr_data = seq[idx]; idx++; end
          else wr_en = 1'b0;
          @(negedge clk);
          wr_en = 1'b0;
          chk(dma_req == 0 || tx_empty == 1, "R8 request implies empty",
              {dma_req, tx_empty}, 2'b11);
        end
      end
      begin
        wait_start("R8 stream start");
        for (int i = 0; i < 6; i++) check_frame(seq[i], 2, "R8 stream frame");
        chk(busy == 0, "R6 stream ends", int'(busy), 0);
      end
    join
    chk(overrun == 0, "R9 no overrun under request pacing", int'(overrun), 0);
    chk(dma_req == 1, "R8 request after stream", int'(dma_req), 1);

    finish_run();
  end
endmodule